// File: doc/BRIEF.md
# Serial Shift-Register Output Driver

This block takes a parallel output word, for example a set of PWM or LED channel levels, and sends it one bit at a time to an external serial-in/parallel-out chip. It drives three pins: serial data, a serial clock made by dividing the bus clock, and a latch strobe for chips that have a storage register. Software-facing register decoding and waveform generation sit elsewhere. This block only sees a divisor code, a delay code, a mode flag, the word and a start request.

A transfer begins when `start` is high on a clock edge while the block is idle. The block captures the word and all settings at that edge and keeps them for the whole transfer. It shifts the word out most significant bit first. Each data change happens while the serial clock is low, and the rising edge comes a programmable number of bus cycles later. That delay is clamped to half a serial period, so every clock period stays half low and half high.

In latched mode a latch pulse follows the final bit so that the external outputs update together. In unlatched mode no pulse is sent, and the external outputs change as the bits shift in. `done` pulses for one cycle when the transfer ends.

Top module: `serial_sr_driver`

## Requirements
- R1: The serial clock period in bus cycles is set by `div_code`: 2'b00 gives 32, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16. Within each period the clock is high for exactly half the period and low for the other half.
- R2: The requested delay is `dly_code`+1 bus cycles, a range of 1 to 16. Counting from the cycle in which a bit appears on `sdata`, the serial clock goes high after that many cycles.
- R3: When the requested delay is larger than half the period, the delay actually used is half the period.
- R4: The word is `WORD_W` (16) bits wide and is sent MSB first, one bit per serial period. `sdata` changes only at the start of a bit period, while `sclk` is low.
- R5: With `latched_mode` set, `slatch` goes high exactly when the final serial clock falls, which is half a period after the final rise. It stays high for half a period. A transfer therefore occupies 16×period + delay bus cycles, and `sclk` and `slatch` are never high together.
- R6: With `latched_mode` clear, `slatch` stays low and a transfer occupies 16×period bus cycles.
- R7: A start request that arrives while `busy` is high is ignored and does not disturb the transfer in progress.
- R8: At the end of a transfer `busy` falls and `done` is high for exactly one cycle, in the same cycle.
- R9: The word, `div_code`, `dly_code` and `latched_mode` are captured at the accepted start. Changes to these inputs during a transfer have no effect on it.
- R10: During and after reset, and whenever the block is idle, `sdata`, `sclk`, `slatch`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 2 | Serial clock divisor select |
| dly_code | input | 4 | Data-to-clock delay select, value minus one |
| latched_mode | input | 1 | Send a latch pulse after the last bit |
| word | input | WORD_W | Parallel word to send |
| start | input | 1 | Transfer request |
| sdata | output | 1 | Serial data |
| sclk | output | 1 | Serial clock |
| slatch | output | 1 | Latch strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench compares every pin on every cycle of each transfer against a cycle-indexed model. It runs the shortest divisor with the largest delay code, where a design missing the clamp would let the rise slip past mid-period and stretch the clock low time. Latched transfers check that the latch waits for the last falling edge and that the transfer is extended by the delay; a latch that came too early or overlapped the clock would show up as a mismatch on the latch pin. Partway through some transfers the bench pulses start again and scrambles the word and settings, so a design that restarted or re-sampled its inputs would put out the wrong bits or the wrong timing.

// File: rtl/srdrv_pkg.sv
package srdrv_pkg;
  localparam int DEF_WORD_W = 16;
  localparam int MAX_PERIOD = 32;
  localparam int CNT_W      = $clog2(MAX_PERIOD + MAX_PERIOD / 2 + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t period;
    cnt_t half;
    cnt_t lead;
    logic latched;
  } cfg_t;

  function automatic cnt_t period_of(input logic [1:0] code);
    case (code)
      2'd1:    return cnt_t'(4);
      2'd2:    return cnt_t'(8);
      2'd3:    return cnt_t'(16);
      default: return cnt_t'(32);
    endcase
  endfunction
endpackage

// File: rtl/srdrv_cfg.sv
module srdrv_cfg
  import srdrv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       busy_i,
  input  logic [1:0] div_code_i,
  input  logic [3:0] dly_code_i,
  input  logic       latched_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q, cfg_d, cfg_new;
  cnt_t req;

  always_comb begin
    cfg_new.period  = period_of(div_code_i);
    cfg_new.half    = cfg_new.period >> 1;
    req             = cnt_t'(dly_code_i) + cnt_t'(1);
    cfg_new.lead    = (req > cfg_new.half) ? cfg_new.half : req;
    cfg_new.latched = latched_i;
    cfg_d           = load_i ? cfg_new : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.period  <= cnt_t'(32);
      cfg_q.half    <= cnt_t'(16);
      cfg_q.lead    <= cnt_t'(1);
      cfg_q.latched <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  // R9: settings captured at start stay fixed while a transfer runs
  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && $past(busy_i) |-> $stable(cfg_q));
  // R3: the delay in use never exceeds half a period
  assert_lead_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lead >= cnt_t'(1) && cfg_q.lead <= cfg_q.half);
endmodule

// File: rtl/srdrv_seq.sv
module srdrv_seq
  import srdrv_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  cfg_t cfg_i,
  output logic accept_o,
  output logic advance_o,
  output logic finish_o,
  output logic busy_o,
  output logic sclk_o,
  output logic latch_o,
  output logic done_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic             busy_q, busy_d;
  cnt_t             cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sclk_q, sclk_d;
  logic             latch_q, latch_d;
  logic             done_q, done_d;
  logic             last_bit, at_end;
  cnt_t             end_cnt;

  always_comb begin
    last_bit  = (idx_q == LAST_IDX);
    end_cnt   = (last_bit && cfg_i.latched) ? cfg_i.lead + cfg_i.period - cnt_t'(1)
                                            : cfg_i.period - cnt_t'(1);
    at_end    = busy_q && (cnt_q == end_cnt);
    accept_o  = start_i && !busy_q;
    advance_o = at_end && !last_bit;
    finish_o  = at_end && last_bit;

    busy_d = busy_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      idx_d  = '0;
    end else if (busy_q) begin
      if (at_end) begin
        cnt_d = '0;
        if (last_bit) begin
          busy_d = 1'b0;
          idx_d  = '0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end else begin
        cnt_d = cnt_q + cnt_t'(1);
      end
    end

    sclk_d  = busy_d && (cnt_d >= cfg_i.lead) && (cnt_d < cfg_i.lead + cfg_i.half);
    latch_d = busy_d && cfg_i.latched && (idx_d == LAST_IDX) &&
              (cnt_d >= cfg_i.lead + cfg_i.half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sclk_q  <= sclk_d;
      latch_q <= latch_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = busy_q;
  assign sclk_o  = sclk_q;
  assign latch_o = latch_q;
  assign done_o  = done_q;

  // R5: latch strobe and serial clock never overlap
  assert_clk_latch_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_q && latch_q));
  // R6: no latch pulse when the captured mode is unlatched
  assert_no_latch_unlatched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.latched |-> !latch_q);
  // R7: a start during a transfer does not end or restart it
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_i && !at_end |=> busy_q && (cnt_q != '0 || idx_q != '0));
  // R8: done is a single-cycle pulse that coincides with busy low
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && $past(busy_q));
  // R10: idle pins stay low
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q && !latch_q);
endmodule

// File: rtl/srdrv_shift.sv
module srdrv_shift #(
  parameter int WORD_W = srdrv_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic              finish_i,
  input  logic              sclk_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sdata_o
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sdata_q, sdata_d;

  always_comb begin
    sh_d    = sh_q;
    sdata_d = sdata_q;
    if (load_i) begin
      sh_d    = word_i;
      sdata_d = word_i[WORD_W-1];
    end else if (advance_i) begin
      sh_d    = sh_q << 1;
      sdata_d = sh_q[WORD_W-2];
    end else if (finish_i) begin
      sdata_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      sdata_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      sdata_q <= sdata_d;
    end
  end

  assign sdata_o = sdata_q;

  // R4: data holds steady across a high serial clock
  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_i && $past(sclk_i) |-> $stable(sdata_q));
endmodule

// File: rtl/serial_sr_driver.sv
module serial_sr_driver
  import srdrv_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        div_code,
  input  logic [3:0]        dly_code,
  input  logic              latched_mode,
  input  logic [WORD_W-1:0] word,
  input  logic              start,
  output logic              sdata,
  output logic              sclk,
  output logic              slatch,
  output logic              busy,
  output logic              done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       accept, advance, finish;
  cfg_t       cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  srdrv_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (accept),
    .busy_i     (busy),
    .div_code_i (div_code),
    .dly_code_i (dly_code),
    .latched_i  (latched_mode),
    .cfg_o      (cfg)
  );

  srdrv_seq #(.WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .cfg_i     (cfg),
    .accept_o  (accept),
    .advance_o (advance),
    .finish_o  (finish),
    .busy_o    (busy),
    .sclk_o    (sclk),
    .latch_o   (slatch),
    .done_o    (done)
  );

  srdrv_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (accept),
    .advance_i (advance),
    .finish_i  (finish),
    .sclk_i    (sclk),
    .word_i    (word),
    .sdata_o   (sdata)
  );
endmodule

// File: tb/serial_sr_driver_test.sv
module serial_sr_driver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  div_code = '0;
  logic [3:0]  dly_code = '0;
  logic        latched_mode = 1'b0;
  logic [15:0] word = '0;
  logic        start = 1'b0;
  logic        sdata, sclk, slatch, busy, done;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  serial_sr_driver uut (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .dly_code(dly_code),
    .latched_mode(latched_mode), .word(word), .start(start),
    .sdata(sdata), .sclk(sclk), .slatch(slatch), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_period(input logic [1:0] code);
    case (code)
      2'd1: return 4;
      2'd2: return 8;
      2'd3: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int exp_lead(input logic [1:0] code, input logic [3:0] dc);
    int h = exp_period(code) / 2;
    int d = int'(dc) + 1;
    return (d > h) ? h : d;
  endfunction

  task automatic run_xfer(input logic [1:0] ds, input logic [3:0] dc, input logic lm,
                          input logic [15:0] w, input bit mutate);
    int per  = exp_period(ds);
    int half = per / 2;
    int d    = exp_lead(ds, dc);
    int tot  = 16 * per + (lm ? d : 0);
    @(negedge clk);
    div_code = ds; dly_code = dc; latched_mode = lm; word = w; start = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= tot; k++) begin
      int b, c;
      @(negedge clk);
      start = 1'b0;
      if (k < tot) begin
        b = k / per;
        if (b > 15) b = 15;
        c = k - b * per;
        check("R4 R9 sdata", int'(sdata), int'(w[15-b]));
        check("R1 R2 R3 sclk", int'(sclk), (c >= d && c < d + half) ? 1 : 0);
        check(lm ? "R5 slatch" : "R6 slatch", int'(slatch),
              (lm && b == 15 && c >= d + half) ? 1 : 0);
        check("R8 busy", int'(busy), 1);
        check("R8 done", int'(done), 0);
        if (mutate && k == 6) check("R7 busy after ignored start", int'(busy), 1);
      end else begin
        check("R8 done at end", int'(done), 1);
        check("R8 busy at end", int'(busy), 0);
        check("R10 idle sdata", int'(sdata), 0);
        check("R10 idle sclk", int'(sclk), 0);
        check("R10 idle slatch", int'(slatch), 0);
      end
      if (mutate && k == 5) begin
        div_code = 2'($urandom); dly_code = 4'($urandom);
        latched_mode = 1'($urandom); word = 16'($urandom); start = 1'b1;
      end
    end
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
    check("R10 idle busy", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    check("R10 reset sdata", int'(sdata), 0);
    check("R10 reset sclk", int'(sclk), 0);
    check("R10 reset slatch", int'(slatch), 0);
    check("R10 reset busy", int'(busy), 0);
    check("R10 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release busy", int'(busy), 0);

    run_xfer(2'd0, 4'd0, 1'b0, 16'hA5A5, 1'b0);
    run_xfer(2'd1, 4'd15, 1'b1, 16'h8001, 1'b0);
    run_xfer(2'd1, 4'd0, 1'b0, 16'hFFFF, 1'b0);
    run_xfer(2'd2, 4'd3, 1'b1, 16'h0000, 1'b0);
    run_xfer(2'd3, 4'd7, 1'b1, 16'h7FFE, 1'b1);
    run_xfer(2'd0, 4'd15, 1'b1, 16'h1234, 1'b1);
    run_xfer(2'd2, 4'd15, 1'b0, 16'hC3C3, 1'b1);
    for (int i = 0; i < 16; i++) begin
      run_xfer(2'($urandom), 4'($urandom), 1'($urandom), 16'($urandom), 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule